// File: doc/BRIEF.md
# Prefixed Opcode Length and Cycle Predecoder

This block sits at the front of an instruction fetch path for a byte-stream instruction set. Instruction bytes arrive one per accepted cycle, qualified by a valid strobe. Three page-select bytes (0x18, 0x1A, 0xCD) may come ahead of an opcode, and each one changes what the next opcode means. The same opcode byte can therefore select an X-indexed form, a Y-indexed form, or a different 16-bit compare, and each of these has its own cycle cost.

The decoder follows the prefix state and resolves the opcode against the page in force. It then consumes the operand bytes that the addressing mode needs. After the last byte of the instruction it reports, for one cycle, the operation, the addressing mode, which index register is used, the operand length and the execution cycle count. Any sequence outside the supported subset raises a one-cycle illegal pulse and sends the decoder back to idle. Nothing is executed and no memory is touched.

Top module: `hcd_predec`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, dec_valid_o and illegal_o are 0 and cycles_o is 0. A reset in the middle of an instruction drops any pending prefix, so the next opcode is decoded on the base page.
- R2: The single-byte opcodes 0x11, 0x0C, 0x0E, 0x4F, 0x5F, 0x0A, 0x43, 0x53, 0x19, 0x4A and 0x5A report mode 0 (no operand), operand count 0 and 2 cycles. The report comes in the cycle after the byte is accepted.
- R3: Without a prefix, the memory-clear, memory-invert and memory-decrement opcodes are 0x7F, 0x73 and 0x7A (extended, 6 cycles) and 0x6F, 0x63 and 0x6A (X-indexed, 6 cycles). The 8-bit compare with A uses 0x81, 0x91, 0xB1 and 0xA1, which are immediate, direct, extended and X-indexed at 2, 3, 4 and 4 cycles. The compare with B uses 0xC1, 0xD1, 0xF1 and 0xE1 with the same modes and cycle counts.
- R4: Without a prefix, the 16-bit compare against X uses 0x8C, 0x9C, 0xBC and 0xAC, which are immediate, direct, extended and X-indexed at 4, 5, 6 and 6 cycles.
- R5: Prefix 0x18 before 0x6F, 0x63 or 0x6A gives the Y-indexed form at 7 cycles. Prefix 0x18 before 0xA1 or 0xE1 gives the Y-indexed 8-bit compare at 5 cycles. In every Y-indexed report idx_y_o is 1.
- R6: The 16-bit compare against Y is 0x18 followed by 0x8C, 0x9C, 0xBC or 0xAC, which are immediate, direct, extended and Y-indexed at 5, 6, 7 and 7 cycles. The sequence 0x1A 0xAC gives its X-indexed form at 7 cycles.
- R7: The 16-bit compare against D is 0x1A followed by 0x83, 0x93, 0xB3 or 0xA3, which are immediate, direct, extended and X-indexed at 5, 6, 7 and 7 cycles. The sequence 0xCD 0xA3 gives the Y-indexed D compare and 0xCD 0xAC gives the Y-indexed X compare, each at 7 cycles.
- R8: mode_o codes: 0 none, 1 immediate, 2 direct, 3 extended, 4 indexed. The operand count is 2 for extended and for 16-bit immediate, and 1 for direct, indexed and 8-bit immediate. The decoder accepts exactly that many further valid bytes and reports in the cycle after the last one. Prefix, opcode and operand bytes before the last one produce no report.
- R9: An unlisted opcode on the base page, an unlisted byte after a prefix, and a prefix after a prefix each give illegal_o high for one cycle, in the cycle after that byte. The decoder is then idle, and illegal_o and dec_valid_o are never high together.
- R10: A byte presented in the cycle that shows a report is accepted as the first byte of a new instruction. Cycles with byte_valid_i low change nothing.
- R11: op_o codes: 1 A-B compare, 2 clear carry, 3 clear interrupt mask, 4 clear A, 5 clear B, 6 clear overflow, 7 invert A, 8 invert B, 9 decimal adjust, 10 decrement A, 11 decrement B, 12 clear memory, 13 invert memory, 14 decrement memory, 15 compare A 8-bit, 16 compare B 8-bit, 17 compare D 16-bit, 18 compare X 16-bit, 19 compare Y 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | byte_i holds an instruction byte this cycle |
| byte_i | input | 8 | Instruction byte |
| dec_valid_o | output | 1 | One-cycle strobe: a complete instruction was decoded |
| illegal_o | output | 1 | One-cycle strobe: unsupported byte sequence |
| op_o | output | 5 | Resolved operation code |
| mode_o | output | 3 | Addressing mode code |
| idx_y_o | output | 1 | Indexed form uses Y instead of X |
| opnd_cnt_o | output | 2 | Number of operand bytes |
| cycles_o | output | 3 | Execution cycle count |

## Verification
Several rules are checked by the assertions on every cycle. A report and an illegal pulse never come together, and each one follows an accepted byte. Every no-operand report shows zero operands and two cycles. Extended and indexed reports carry the right operand count, and Y-indexed forms never cost fewer than five cycles. Only the bench scenarios can show that each prefix resolves to the right operation and count, that operand bytes are consumed across gaps in byte_valid_i, that back-to-back instructions decode without a stall, and that a reset drops a pending prefix.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;
  localparam int CYC_W  = 3;
  localparam int OP_W   = 5;
  localparam int MD_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 0, OP_CMP_AB, OP_CLR_C, OP_CLR_I, OP_CLR_A, OP_CLR_B, OP_CLR_V,
    OP_NOT_A, OP_NOT_B, OP_BCD_ADJ, OP_DECR_A, OP_DECR_B, OP_CLR_M, OP_NOT_M,
    OP_DECR_M, OP_CMP8_A, OP_CMP8_B, OP_CMP16_D, OP_CMP16_X, OP_CMP16_Y
  } op_e;

  typedef enum logic [MD_W-1:0] {
    MD_INH = 0, MD_IMM = 1, MD_DIR = 2, MD_EXT = 3, MD_IDX = 4
  } mode_e;

  typedef enum logic [1:0] {PG_BASE, PG_P18, PG_P1A, PG_PCD} page_e;

  typedef struct packed {
    logic             legal;
    logic             pfx;
    page_e            pg;
    op_e              op;
    mode_e            mode;
    logic             idx_y;
    logic [CNT_W-1:0] nopnd;
    logic [CYC_W-1:0] cyc;
  } dec_t;
endpackage

// File: rtl/hcd_table.sv
module hcd_table
  import hcd_pkg::*;
(
  input  page_e             page_i,
  input  logic [BYTE_W-1:0] byte_i,
  output dec_t              dec_o
);
  function automatic dec_t ent(op_e op, mode_e m, logic y, int unsigned c);
    dec_t d;
    d       = '0;
    d.legal = 1'b1;
    d.op    = op;
    d.mode  = m;
    d.idx_y = y;
    d.cyc   = CYC_W'(c);
    return d;
  endfunction

  dec_t raw;

  always_comb begin
    raw = '0;
    case (page_i)
      PG_BASE: case (byte_i)
        8'h18: begin raw.pfx = 1'b1; raw.pg = PG_P18; end
        8'h1A: begin raw.pfx = 1'b1; raw.pg = PG_P1A; end
        8'hCD: begin raw.pfx = 1'b1; raw.pg = PG_PCD; end
        8'h11: raw = ent(OP_CMP_AB,  MD_INH, 1'b0, 2);
        8'h0C: raw = ent(OP_CLR_C,   MD_INH, 1'b0, 2);
        8'h0E: raw = ent(OP_CLR_I,   MD_INH, 1'b0, 2);
        8'h4F: raw = ent(OP_CLR_A,   MD_INH, 1'b0, 2);
        8'h5F: raw = ent(OP_CLR_B,   MD_INH, 1'b0, 2);
        8'h0A: raw = ent(OP_CLR_V,   MD_INH, 1'b0, 2);
        8'h43: raw = ent(OP_NOT_A,   MD_INH, 1'b0, 2);
        8'h53: raw = ent(OP_NOT_B,   MD_INH, 1'b0, 2);
        8'h19: raw = ent(OP_BCD_ADJ, MD_INH, 1'b0, 2);
        8'h4A: raw = ent(OP_DECR_A,  MD_INH, 1'b0, 2);
        8'h5A: raw = ent(OP_DECR_B,  MD_INH, 1'b0, 2);
        8'h7F: raw = ent(OP_CLR_M,   MD_EXT, 1'b0, 6);
        8'h6F: raw = ent(OP_CLR_M,   MD_IDX, 1'b0, 6);
        8'h73: raw = ent(OP_NOT_M,   MD_EXT, 1'b0, 6);
        8'h63: raw = ent(OP_NOT_M,   MD_IDX, 1'b0, 6);
        8'h7A: raw = ent(OP_DECR_M,  MD_EXT, 1'b0, 6);
        8'h6A: raw = ent(OP_DECR_M,  MD_IDX, 1'b0, 6);
        8'h81: raw = ent(OP_CMP8_A,  MD_IMM, 1'b0, 2);
        8'h91: raw = ent(OP_CMP8_A,  MD_DIR, 1'b0, 3);
        8'hB1: raw = ent(OP_CMP8_A,  MD_EXT, 1'b0, 4);
        8'hA1: raw = ent(OP_CMP8_A,  MD_IDX, 1'b0, 4);
        8'hC1: raw = ent(OP_CMP8_B,  MD_IMM, 1'b0, 2);
        8'hD1: raw = ent(OP_CMP8_B,  MD_DIR, 1'b0, 3);
        8'hF1: raw = ent(OP_CMP8_B,  MD_EXT, 1'b0, 4);
        8'hE1: raw = ent(OP_CMP8_B,  MD_IDX, 1'b0, 4);
        8'h8C: raw = ent(OP_CMP16_X, MD_IMM, 1'b0, 4);
        8'h9C: raw = ent(OP_CMP16_X, MD_DIR, 1'b0, 5);
        8'hBC: raw = ent(OP_CMP16_X, MD_EXT, 1'b0, 6);
        8'hAC: raw = ent(OP_CMP16_X, MD_IDX, 1'b0, 6);
        default: ;
      endcase
      PG_P18: case (byte_i)
        8'h6F: raw = ent(OP_CLR_M,   MD_IDX, 1'b1, 7);
        8'h63: raw = ent(OP_NOT_M,   MD_IDX, 1'b1, 7);
        8'h6A: raw = ent(OP_DECR_M,  MD_IDX, 1'b1, 7);
        8'hA1: raw = ent(OP_CMP8_A,  MD_IDX, 1'b1, 5);
        8'hE1: raw = ent(OP_CMP8_B,  MD_IDX, 1'b1, 5);
        8'h8C: raw = ent(OP_CMP16_Y, MD_IMM, 1'b0, 5);
        8'h9C: raw = ent(OP_CMP16_Y, MD_DIR, 1'b0, 6);
        8'hBC: raw = ent(OP_CMP16_Y, MD_EXT, 1'b0, 7);
        8'hAC: raw = ent(OP_CMP16_Y, MD_IDX, 1'b1, 7);
        default: ;
      endcase
      PG_P1A: case (byte_i)
        8'h83: raw = ent(OP_CMP16_D, MD_IMM, 1'b0, 5);
        8'h93: raw = ent(OP_CMP16_D, MD_DIR, 1'b0, 6);
        8'hB3: raw = ent(OP_CMP16_D, MD_EXT, 1'b0, 7);
        8'hA3: raw = ent(OP_CMP16_D, MD_IDX, 1'b0, 7);
        8'hAC: raw = ent(OP_CMP16_Y, MD_IDX, 1'b0, 7);
        default: ;
      endcase
      default: case (byte_i)
        8'hA3: raw = ent(OP_CMP16_D, MD_IDX, 1'b1, 7);
        8'hAC: raw = ent(OP_CMP16_X, MD_IDX, 1'b1, 7);
        default: ;
      endcase
    endcase
  end

  // operand length follows from mode and immediate width
  logic wide;
  always_comb begin
    wide  = (raw.op == OP_CMP16_D) || (raw.op == OP_CMP16_X) || (raw.op == OP_CMP16_Y);
    dec_o = raw;
    case (raw.mode)
      MD_INH:  dec_o.nopnd = CNT_W'(0);
      MD_EXT:  dec_o.nopnd = CNT_W'(2);
      MD_IMM:  dec_o.nopnd = wide ? CNT_W'(2) : CNT_W'(1);
      default: dec_o.nopnd = CNT_W'(1);
    endcase
    if (!raw.legal) dec_o.nopnd = '0;
  end
endmodule

// File: rtl/hcd_seq.sv
module hcd_seq
  import hcd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  byte_valid_i,
  input  dec_t  tbl_i,
  output page_e page_o,
  output dec_t  rpt_o,
  output logic  rpt_valid_o,
  output logic  illegal_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PFX, ST_OPND} st_e;

  st_e              st_q;
  page_e            page_q;
  dec_t             hold_q, rpt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rv_q, ill_q;

  assign page_o      = (st_q == ST_PFX) ? page_q : PG_BASE;
  assign rpt_o       = rpt_q;
  assign rpt_valid_o = rv_q;
  assign illegal_o   = ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      page_q <= PG_BASE;
      hold_q <= '0;
      rpt_q  <= '0;
      cnt_q  <= '0;
      rv_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      rv_q  <= 1'b0;
      ill_q <= 1'b0;
      if (byte_valid_i) begin
        case (st_q)
          ST_OPND: begin
            if (cnt_q == CNT_W'(1)) begin
              rpt_q <= hold_q;
              rv_q  <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: begin
            // prefix flag only appears on the base page
            if (tbl_i.pfx) begin
              page_q <= tbl_i.pg;
              st_q   <= ST_PFX;
            end else if (!tbl_i.legal) begin
              ill_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else if (tbl_i.nopnd == '0) begin
              rpt_q <= tbl_i;
              rv_q  <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              hold_q <= tbl_i;
              cnt_q  <= tbl_i.nopnd;
              st_q   <= ST_OPND;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hcd_predec.sv
module hcd_predec
  import hcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              dec_valid_o,
  output logic              illegal_o,
  output logic [OP_W-1:0]   op_o,
  output logic [MD_W-1:0]   mode_o,
  output logic              idx_y_o,
  output logic [CNT_W-1:0]  opnd_cnt_o,
  output logic [CYC_W-1:0]  cycles_o
);
  page_e page;
  dec_t  tbl, rpt;

  hcd_table u_table (
    .page_i (page),
    .byte_i (byte_i),
    .dec_o  (tbl)
  );

  hcd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .tbl_i        (tbl),
    .page_o       (page),
    .rpt_o        (rpt),
    .rpt_valid_o  (dec_valid_o),
    .illegal_o    (illegal_o)
  );

  assign op_o       = rpt.op;
  assign mode_o     = rpt.mode;
  assign idx_y_o    = rpt.idx_y;
  assign opnd_cnt_o = rpt.nopnd;
  assign cycles_o   = rpt.cyc;
endmodule

// File: rtl/hcd_chk.sv
module hcd_chk
  import hcd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              dec_valid_o,
  input logic              illegal_o,
  input logic [OP_W-1:0]   op_o,
  input logic [MD_W-1:0]   mode_o,
  input logic              idx_y_o,
  input logic [CNT_W-1:0]  opnd_cnt_o,
  input logic [CYC_W-1:0]  cycles_o
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_valid_o && illegal_o)); // R9
  AST_ILL_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(byte_valid_i)); // R9
  AST_RPT_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i)); // R10
  AST_INH_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && mode_o == MD_INH) |-> (opnd_cnt_o == 2'd0 && cycles_o == 3'd2)); // R2
  AST_EXT_TWO_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && mode_o == MD_EXT) |-> opnd_cnt_o == 2'd2); // R8
  AST_IDX_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && mode_o == MD_IDX) |-> opnd_cnt_o == 2'd1); // R8
  AST_Y_IDX_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && idx_y_o) |-> (mode_o == MD_IDX && cycles_o >= 3'd5)); // R5
  AST_CYC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (cycles_o >= 3'd2 && op_o != 5'd0)); // R3
endmodule

bind hcd_predec hcd_chk u_chk (.*);

// File: tb/sim_hcd_predec.sv
module sim_hcd_predec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       dec_valid_o, illegal_o, idx_y_o;
  logic [4:0] op_o;
  logic [2:0] mode_o, cycles_o;
  logic [1:0] opnd_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;

  hcd_predec u0 (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  typedef struct packed {
    logic       ok;
    logic [4:0] op;
    logic [2:0] md;
    logic       y;
    logic [1:0] n;
    logic [2:0] c;
  } exp_t;

  function automatic exp_t mk(int op, int md, int y, int c);
    exp_t e;
    e.ok = 1'b1; e.op = op[4:0]; e.md = md[2:0]; e.y = y[0]; e.c = c[2:0];
    if (md == 0) e.n = 2'd0;
    else if (md == 3 || (md == 1 && op >= 17)) e.n = 2'd2;
    else e.n = 2'd1;
    return e;
  endfunction

  // pg: 0 none, 1 after 0x18, 2 after 0x1A, 3 after 0xCD
  function automatic exp_t ref_dec(int pg, logic [7:0] b);
    exp_t e = '0;
    if (pg == 0) begin
      case (b)
        8'h11: e = mk(1, 0, 0, 2);  8'h0C: e = mk(2, 0, 0, 2);
        8'h0E: e = mk(3, 0, 0, 2);  8'h4F: e = mk(4, 0, 0, 2);
        8'h5F: e = mk(5, 0, 0, 2);  8'h0A: e = mk(6, 0, 0, 2);
        8'h43: e = mk(7, 0, 0, 2);  8'h53: e = mk(8, 0, 0, 2);
        8'h19: e = mk(9, 0, 0, 2);  8'h4A: e = mk(10, 0, 0, 2);
        8'h5A: e = mk(11, 0, 0, 2);
        8'h7F: e = mk(12, 3, 0, 6); 8'h6F: e = mk(12, 4, 0, 6);
        8'h73: e = mk(13, 3, 0, 6); 8'h63: e = mk(13, 4, 0, 6);
        8'h7A: e = mk(14, 3, 0, 6); 8'h6A: e = mk(14, 4, 0, 6);
        8'h81: e = mk(15, 1, 0, 2); 8'h91: e = mk(15, 2, 0, 3);
        8'hB1: e = mk(15, 3, 0, 4); 8'hA1: e = mk(15, 4, 0, 4);
        8'hC1: e = mk(16, 1, 0, 2); 8'hD1: e = mk(16, 2, 0, 3);
        8'hF1: e = mk(16, 3, 0, 4); 8'hE1: e = mk(16, 4, 0, 4);
        8'h8C: e = mk(18, 1, 0, 4); 8'h9C: e = mk(18, 2, 0, 5);
        8'hBC: e = mk(18, 3, 0, 6); 8'hAC: e = mk(18, 4, 0, 6);
        default: ;
      endcase
    end else if (pg == 1) begin
      case (b)
        8'h6F: e = mk(12, 4, 1, 7); 8'h63: e = mk(13, 4, 1, 7);
        8'h6A: e = mk(14, 4, 1, 7);
        8'hA1: e = mk(15, 4, 1, 5); 8'hE1: e = mk(16, 4, 1, 5);
        8'h8C: e = mk(19, 1, 0, 5); 8'h9C: e = mk(19, 2, 0, 6);
        8'hBC: e = mk(19, 3, 0, 7); 8'hAC: e = mk(19, 4, 1, 7);
        default: ;
      endcase
    end else if (pg == 2) begin
      case (b)
        8'h83: e = mk(17, 1, 0, 5); 8'h93: e = mk(17, 2, 0, 6);
        8'hB3: e = mk(17, 3, 0, 7); 8'hA3: e = mk(17, 4, 0, 7);
        8'hAC: e = mk(19, 4, 0, 7);
        default: ;
      endcase
    end else begin
      case (b)
        8'hA3: e = mk(17, 4, 1, 7); 8'hAC: e = mk(18, 4, 1, 7);
        default: ;
      endcase
    end
    return e;
  endfunction

  function automatic string tag_of(int pg, exp_t e);
    if (e.op == 5'd19) return "R6";
    if (e.op == 5'd17 || pg == 3) return "R7";
    if (pg == 1) return "R5";
    if (e.op == 5'd18) return "R4";
    if (e.md == 3'd0) return "R2";
    return "R3";
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic chk_rpt(string req, exp_t e);
    chk(req, "dec_valid", int'(dec_valid_o), 1);
    chk("R11", "op", int'(op_o), int'(e.op));
    chk("R8", "mode", int'(mode_o), int'(e.md));
    chk(req, "idx_y", int'(idx_y_o), int'(e.y));
    chk("R8", "opnd_cnt", int'(opnd_cnt_o), int'(e.n));
    chk(req, "cycles", int'(cycles_o), int'(e.c));
  endtask

  // returns at the negedge after the accepting edge
  task automatic put_byte(logic [7:0] b);
    @(negedge clk_i);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0; byte_i = 8'($urandom);
  endtask

  task automatic run_instr(int pg, logic [7:0] b, bit gaps);
    exp_t e;
    if (pg == 1) put_byte(8'h18);
    else if (pg == 2) put_byte(8'h1A);
    else if (pg == 3) put_byte(8'hCD);
    if (pg != 0) chk("R8", "quiet after prefix", int'(dec_valid_o | illegal_o), 0);
    put_byte(b);
    e = ref_dec(pg, b);
    if (!e.ok) begin
      chk("R9", "illegal", int'(illegal_o), 1);
      chk("R9", "no report", int'(dec_valid_o), 0);
      return;
    end
    for (int k = 0; k < int'(e.n); k++) begin
      chk("R8", "no early report", int'(dec_valid_o), 0);
      if (gaps) begin
        repeat ($urandom % 3) begin
          @(negedge clk_i);
          chk("R10", "idle no report", int'(dec_valid_o), 0);
        end
      end
      put_byte(8'($urandom));
    end
    chk_rpt(tag_of(pg, e), e);
  endtask

  logic [7:0] pool [36] = '{8'h11, 8'h0C, 8'h0E, 8'h4F, 8'h5F, 8'h0A, 8'h43, 8'h53,
                            8'h19, 8'h4A, 8'h5A, 8'h7F, 8'h6F, 8'h73, 8'h63, 8'h7A,
                            8'h6A, 8'h81, 8'h91, 8'hB1, 8'hA1, 8'hC1, 8'hD1, 8'hF1,
                            8'hE1, 8'h8C, 8'h9C, 8'hBC, 8'hAC, 8'h83, 8'h93, 8'hB3,
                            8'hA3, 8'h18, 8'h1A, 8'hCD};

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk_i);
    chk("R1", "valid in reset", int'(dec_valid_o), 0);
    chk("R1", "illegal in reset", int'(illegal_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "valid after reset", int'(dec_valid_o), 0);
    chk("R1", "cycles after reset", int'(cycles_o), 0);

    // directed corner cases
    run_instr(1, 8'h6F, 1'b0);
    run_instr(2, 8'h83, 1'b1);
    run_instr(3, 8'hAC, 1'b0);
    run_instr(2, 8'hAC, 1'b0);
    run_instr(1, 8'h18, 1'b0);   // R9 prefix after prefix
    run_instr(3, 8'h1A, 1'b0);   // R9
    run_instr(0, 8'h00, 1'b0);   // R9 unlisted base opcode
    run_instr(0, 8'hBC, 1'b1);

    // R10 byte held with valid low is ignored
    @(negedge clk_i);
    byte_i = 8'h11;
    repeat (4) @(negedge clk_i);
    chk("R10", "invalid byte ignored", int'(dec_valid_o | illegal_o), 0);

    // R10 back-to-back single-byte instructions
    @(negedge clk_i);
    byte_valid_i = 1'b1; byte_i = 8'h11;
    @(negedge clk_i);
    chk("R10", "first op", int'(op_o), 1);
    byte_i = 8'h0C;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    chk("R10", "second valid", int'(dec_valid_o), 1);
    chk("R10", "second op", int'(op_o), 2);

    // R1 reset drops pending prefix
    put_byte(8'h18);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1", "valid after mid reset", int'(dec_valid_o), 0);
    run_instr(0, 8'h6F, 1'b0);
    chk("R1", "base page after reset", int'(cycles_o), 6);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int pg;
      logic [7:0] b;
      pg = ($urandom % 4 == 0) ? 0 : int'($urandom % 4);
      b = ($urandom % 4 == 0) ? 8'($urandom) : pool[$urandom % 36];
      if (pg == 0 && (b == 8'h18 || b == 8'h1A || b == 8'hCD)) b = 8'h00;
      run_instr(pg, b, 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule